// File: doc/BRIEF.md
# Configurable CRC Engine

A register-mapped checksum unit that folds bus writes into a running CRC. Software picks one of three generator polynomials and four independent transform flags in a control register. It loads a starting value through the seed register and then streams bytes or whole 32-bit words into the data register. Each accepted write is absorbed in the clock cycle it is presented. The result register holds the folded value.

The input flags act on the written data before it enters the fold. The output flags act only on what the read path shows. Because of this, software can clear the output flags, read the raw running value, and later write that value back as a seed to resume a calculation. Writes to the control register never touch the running value, so a stream can be paused, inspected and continued.

Top module: `crc_eng`

## Requirements
- R1: After reset the control register reads 0 and the running value is 0, so the result register reads 0.
- R2: Register map, selected by `bus_addr`. Address 0 is the control register, read back in bits [5:0]: [1:0] polynomial (0 = 16-bit 0x1021, 1 = 16-bit 0x8005, 2 and 3 = 32-bit 0x04C11DB7), [2] reverse input, [3] complement input, [4] reverse output, [5] complement output. It is written only when `bus_wstrb[0]` is set. Address 1 is the write-only seed register. Address 2 is written as the data port and read as the result. Addresses 1 and 3 read as 0.
- R3: A seed write replaces each byte lane of the running value whose strobe bit is set and keeps the other lanes. The new value is visible on the read path one cycle later.
- R4: A data write with all four strobes set folds the 32-bit word in one cycle, most significant byte first.
- R5: A data write with exactly one strobe set folds the single byte in that lane. Any other strobe pattern on the data port leaves the running value unchanged.
- R6: The fold is MSB-first and non-reflected. 16-bit polynomials use and produce only the low 16 bits of the running value.
- R7: Reverse input mirrors bits within the byte for byte writes and across all 32 bits for word writes. Complement input inverts every written bit before the fold.
- R8: Reverse output mirrors the value across the active width (16 or 32). Complement output inverts the active-width bits. In 16-bit modes, result bits [31:16] read as 0.
- R9: A control-register write never changes the running value. With both output flags clear, the result read equals the raw running value, and writing it back as a seed resumes the calculation exactly.
- R10: The string "123456789" gives the standard check values: 0x29B1 (poly 0, seed 0xFFFF), 0xBB3D (poly 1, seed 0, both reverse flags), 0xCBF43926 (poly 2, seed 0xFFFFFFFF, both reverse flags and complement output), 0x0376E6E7 (poly 2, seed 0xFFFFFFFF, no flags).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_addr | input | 2 | Register word address for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |

## Verification
The bench feeds the same nine-byte string as bytes and as mixed word and byte writes. A wrong byte order inside a word, or reflection applied per byte instead of per word, would then yield a different check value from the byte-only path. It checks that a strobed byte in an upper lane folds like lane 0, and that a two-lane strobe is dropped; a design that decoded width from the lowest strobe would fold garbage. It also clears the output flags mid-stream, reloads the raw value as a seed and finishes the string. A design that applied output transforms to the stored state, or let a control write disturb it, would miss the final check value. In 16-bit modes, it checks that the upper result half stays zero under complement and reversal.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    typedef enum logic [1:0] {
        POLY_CCITT = 2'd0,
        POLY_CRC16 = 2'd1,
        POLY_CRC32 = 2'd2,
        POLY_RSVD  = 2'd3
    } poly_e;

    typedef struct packed {
        logic  cmpl_out;
        logic  rev_out;
        logic  cmpl_in;
        logic  rev_in;
        poly_e poly;
    } mode_t;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_SEED = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_e;

    localparam int MODE_W = $bits(mode_t);
    localparam int CRC_W  = 32;

    localparam logic [CRC_W-1:0] GEN_CCITT = 32'h0000_1021;
    localparam logic [CRC_W-1:0] GEN_CRC16 = 32'h0000_8005;
    localparam logic [CRC_W-1:0] GEN_CRC32 = 32'h04C1_1DB7;

    function automatic logic is_wide(poly_e p);
        return (p == POLY_CRC32) || (p == POLY_RSVD);
    endfunction

    function automatic logic [CRC_W-1:0] gen_of(poly_e p);
        case (p)
            POLY_CCITT: return GEN_CCITT;
            POLY_CRC16: return GEN_CRC16;
            default:    return GEN_CRC32;
        endcase
    endfunction

    function automatic logic [CRC_W-1:0] width_mask(poly_e p);
        return is_wide(p) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [CRC_W-1:0] mirror32(logic [CRC_W-1:0] x);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = x[CRC_W-1-i];
        return r;
    endfunction

    function automatic logic [7:0] mirror8(logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = x[7-i];
        return r;
    endfunction

    // One byte folded MSB-first: xor the byte into the top of the register,
    // then eight shift/reduce steps.
    function automatic logic [CRC_W-1:0] fold_byte(logic [CRC_W-1:0] s,
                                                   logic [7:0] b, poly_e p);
        logic [CRC_W-1:0] c;
        logic [CRC_W-1:0] g;
        g = gen_of(p);
        if (is_wide(p)) begin
            c = s ^ {b, 24'h0};
            for (int k = 0; k < 8; k++)
                c = c[31] ? ((c << 1) ^ g) : (c << 1);
        end else begin
            c = {16'h0, s[15:0] ^ {b, 8'h0}};
            for (int k = 0; k < 8; k++)
                c = c[15] ? (((c << 1) ^ g) & 32'h0000_FFFF)
                          : ((c << 1) & 32'h0000_FFFF);
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_eng_fold.sv
module crc_eng_fold
    import crc_eng_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  mode_t              mode,
    input  logic [CRC_W-1:0]   sum_q,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic [CRC_W-1:0]   next_sum,
    output logic               legal
);
    localparam int LANES = DATA_W / 8;

    logic              is_word;
    logic              is_byte;
    logic [7:0]        lane_b;
    logic [7:0]        byte_x;
    logic [DATA_W-1:0] word_x;
    logic [CRC_W-1:0]  chain [LANES+1];

    always_comb begin
        is_word = (wstrb == '1);
        is_byte = $onehot(wstrb);
        lane_b  = '0;
        for (int i = 0; i < LANES; i++)
            if (wstrb[i]) lane_b = wdata[8*i +: 8];
        byte_x = mode.rev_in ? mirror8(lane_b) : lane_b;
        if (mode.cmpl_in) byte_x = ~byte_x;
        for (int i = 0; i < DATA_W; i++)
            word_x[i] = mode.rev_in ? wdata[DATA_W-1-i] : wdata[i];
        if (mode.cmpl_in) word_x = ~word_x;
    end

    assign chain[0] = sum_q;

    // Unrolled byte stages, top byte of the word first. Stage 0 also serves
    // single-byte writes.
    for (genvar k = 0; k < LANES; k++) begin : g_stage
        logic [7:0] stage_b;
        if (k == 0) begin : g_first
            assign stage_b = is_word ? word_x[DATA_W-1 -: 8] : byte_x;
        end else begin : g_rest
            assign stage_b = word_x[DATA_W-1-8*k -: 8];
        end
        assign chain[k+1] = fold_byte(chain[k], stage_b, mode.poly);
    end

    assign next_sum = is_word ? chain[LANES] : chain[1];
    assign legal    = is_word | is_byte;

endmodule

// File: rtl/crc_eng_regs.sv
module crc_eng_regs
    import crc_eng_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_we,
    input  mode_t               mode_d,
    input  logic                seed_we,
    input  logic [DATA_W-1:0]   seed_d,
    input  logic [DATA_W/8-1:0] seed_strb,
    input  logic                fold_we,
    input  logic [CRC_W-1:0]    fold_d,
    output mode_t               mode_q,
    output logic [CRC_W-1:0]    sum_q
);
    localparam int LANES = DATA_W / 8;

    logic [CRC_W-1:0] seed_merged;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign seed_merged[8*i +: 8] = seed_strb[i] ? seed_d[8*i +: 8]
                                                    : sum_q[8*i +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            sum_q  <= '0;
        end else begin
            if (mode_we) mode_q <= mode_d;
            if (seed_we)
                sum_q <= seed_merged;
            else if (fold_we)
                sum_q <= fold_d;
        end
    end

endmodule

// File: rtl/crc_eng_view.sv
module crc_eng_view
    import crc_eng_pkg::*;
(
    input  mode_t            mode,
    input  logic [CRC_W-1:0] sum_q,
    output logic [CRC_W-1:0] view
);
    logic [CRC_W-1:0] mask;
    logic [CRC_W-1:0] raw;
    logic [CRC_W-1:0] flip;

    always_comb begin
        mask = width_mask(mode.poly);
        raw  = sum_q & mask;
        if (!mode.rev_out)
            flip = raw;
        else if (is_wide(mode.poly))
            flip = mirror32(raw);
        else
            flip = mirror32({raw[15:0], 16'h0});
        view = mode.cmpl_out ? (~flip & mask) : flip;
    end

endmodule

// File: rtl/crc_eng.sv
module crc_eng
    import crc_eng_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W/8-1:0] bus_wstrb,
    output logic [DATA_W-1:0]   bus_rdata
);
    localparam int LANES = DATA_W / 8;

    reg_e             sel;
    mode_t            mode_q;
    logic [CRC_W-1:0] sum_q;
    logic [CRC_W-1:0] next_sum;
    logic [CRC_W-1:0] view;
    logic             legal;
    logic             mode_we;
    logic             seed_we;
    logic             fold_we;

    assign sel     = reg_e'(bus_addr[1:0]);
    assign mode_we = bus_wr && sel == REG_MODE && bus_wstrb[0];
    assign seed_we = bus_wr && sel == REG_SEED;
    assign fold_we = bus_wr && sel == REG_DATA && legal;

    crc_eng_fold #(.DATA_W(DATA_W)) u_fold (
        .mode     (mode_q),
        .sum_q    (sum_q),
        .wdata    (bus_wdata),
        .wstrb    (bus_wstrb),
        .next_sum (next_sum),
        .legal    (legal)
    );

    crc_eng_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .mode_we   (mode_we),
        .mode_d    (mode_t'(bus_wdata[MODE_W-1:0])),
        .seed_we   (seed_we),
        .seed_d    (bus_wdata),
        .seed_strb (bus_wstrb),
        .fold_we   (fold_we),
        .fold_d    (next_sum),
        .mode_q    (mode_q),
        .sum_q     (sum_q)
    );

    crc_eng_view u_view (
        .mode  (mode_q),
        .sum_q (sum_q),
        .view  (view)
    );

    always_comb begin
        case (sel)
            REG_MODE: bus_rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
            REG_DATA: bus_rdata = view;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crc_eng_chk.sv
module crc_eng_chk
    import crc_eng_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [3:0]  bus_wstrb,
    input logic [31:0] bus_rdata,
    input mode_t       mode_q,
    input logic [31:0] sum_q
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sum_q == 32'h0 && mode_q == '0));

    assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && bus_wstrb[0]) |=> mode_q == mode_t'($past(bus_wdata[5:0])));

    assert_seed_full_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1 && bus_wstrb == 4'hF) |=> sum_q == $past(bus_wdata));

    assert_bad_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2 && bus_wstrb != 4'hF && $countones(bus_wstrb) != 1)
        |=> $stable(sum_q));

    assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd2 && (mode_q.poly == POLY_CCITT || mode_q.poly == POLY_CRC16))
        |-> bus_rdata[31:16] == 16'h0);

    assert_mode_keeps_sum_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> $stable(sum_q));
endmodule

bind crc_eng crc_eng_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wstrb (bus_wstrb),
    .bus_rdata (bus_rdata),
    .mode_q    (mode_q),
    .sum_q     (sum_q)
);

// File: tb/crc_eng_bench.sv
module crc_eng_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [3:0]  bus_wstrb = 4'h0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    crc_eng u_crc_eng (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .bus_rdata (bus_rdata)
    );

    localparam logic [1:0] A_MODE = 2'd0, A_SEED = 2'd1, A_DATA = 2'd2, A_NONE = 2'd3;

    // Vector table: control word, seed, word path?, two words, expected result.
    localparam int NV = 8;
    localparam logic [5:0]  V_MODE [NV] = '{6'h00, 6'h00, 6'h20, 6'h15, 6'h36, 6'h36, 6'h22, 6'h02};
    localparam logic [31:0] V_SEED [NV] = '{32'hFFFF, 32'hFFFF, 32'hFFFF, 32'h0,
                                           32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF};
    localparam bit          V_WORD [NV] = '{0, 1, 0, 0, 0, 1, 1, 1};
    localparam logic [31:0] V_W0   [NV] = '{32'h0, 32'h31323334, 32'h0, 32'h0, 32'h0,
                                           32'h34333231, 32'h31323334, 32'h31323334};
    localparam logic [31:0] V_W1   [NV] = '{32'h0, 32'h35363738, 32'h0, 32'h0, 32'h0,
                                           32'h38373635, 32'h35363738, 32'h35363738};
    localparam logic [31:0] V_EXP  [NV] = '{32'h29B1, 32'h29B1, 32'hD64E, 32'hBB3D,
                                           32'hCBF43926, 32'hCBF43926, 32'hFC891918, 32'h0376E6E7};

    // Independent bit-at-a-time reference (message bit xored with feedback).
    function automatic logic [31:0] ref_byte(logic [31:0] s, logic [7:0] b, int poly);
        logic wide;
        logic [31:0] g;
        logic fb;
        wide = (poly >= 2);
        g = (poly == 0) ? 32'h1021 : (poly == 1) ? 32'h8005 : 32'h04C11DB7;
        for (int i = 7; i >= 0; i--) begin
            fb = (wide ? s[31] : s[15]) ^ b[i];
            s = s << 1;
            if (!wide) s = s & 32'hFFFF;
            if (fb) s = s ^ g;
        end
        return s;
    endfunction

    function automatic logic [7:0] flip8(logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = x[7-i];
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_wstrb = 4'h0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] e;
        logic [31:0] raw;
        logic [7:0] str [9];
        for (int i = 0; i < 9; i++) str[i] = 8'h31 + 8'(i);

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state, R2 unmapped reads
        rd(A_MODE, v); check("R1 mode after reset", v, 32'h0);
        rd(A_DATA, v); check("R1 result after reset", v, 32'h0);
        rd(A_SEED, v); check("R2 seed reads zero", v, 32'h0);
        rd(A_NONE, v); check("R2 addr3 reads zero", v, 32'h0);

        // R10 R4 R6 R7 R8: table walk
        for (int n = 0; n < NV; n++) begin
            wr(A_MODE, {26'h0, V_MODE[n]}, 4'hF);
            wr(A_SEED, V_SEED[n], 4'hF);
            if (V_WORD[n]) begin
                wr(A_DATA, V_W0[n], 4'hF);
                wr(A_DATA, V_W1[n], 4'hF);
                wr(A_DATA, 32'h39, 4'h1);
            end else begin
                for (int i = 0; i < 9; i++) wr(A_DATA, {24'h0, str[i]}, 4'h1);
            end
            rd(A_DATA, v);
            check($sformatf("R10 R4 vector %0d", n), v, V_EXP[n]);
        end
        rd(A_MODE, v); check("R2 mode readback", v, 32'h02);

        // R5 upper lane byte
        wr(A_MODE, 32'h00, 4'h1);
        wr(A_SEED, 32'hFFFF, 4'hF);
        wr(A_DATA, 32'h0031_0000, 4'h4);
        e = ref_byte(32'hFFFF, 8'h31, 0);
        rd(A_DATA, v); check("R5 lane2 byte", v, e);
        // R5 two-lane strobe dropped
        wr(A_DATA, 32'h0000_5A5A, 4'h3);
        rd(A_DATA, v); check("R5 illegal strobe ignored", v, e);

        // R7 complement input, byte and word
        wr(A_MODE, 32'h08, 4'h1);
        wr(A_SEED, 32'hFFFF, 4'hF);
        wr(A_DATA, 32'hCE, 4'h1);
        rd(A_DATA, v); check("R7 complement byte", v, ref_byte(32'hFFFF, 8'h31, 0));
        wr(A_MODE, 32'h0A, 4'h1);
        wr(A_SEED, 32'h0, 4'hF);
        wr(A_DATA, 32'hCECDCCCB, 4'hF);
        e = 32'h0;
        for (int i = 0; i < 4; i++) e = ref_byte(e, str[i], 2);
        rd(A_DATA, v); check("R7 complement word", v, e);

        // R8 narrow masking and output transforms
        wr(A_MODE, 32'h00, 4'h1);
        wr(A_SEED, 32'hABCD1234, 4'hF);
        rd(A_DATA, v); check("R8 narrow raw", v, 32'h0000_1234);
        wr(A_MODE, 32'h20, 4'h1);
        rd(A_DATA, v); check("R8 narrow complement", v, 32'h0000_EDCB);
        wr(A_MODE, 32'h10, 4'h1);
        wr(A_SEED, 32'h0001, 4'hF);
        rd(A_DATA, v); check("R8 narrow reverse", v, 32'h0000_8000);
        wr(A_MODE, 32'h12, 4'h1);
        rd(A_DATA, v); check("R8 wide reverse", v, 32'h8000_0000);

        // R3 partial seed
        wr(A_MODE, 32'h02, 4'h1);
        wr(A_SEED, 32'h11223344, 4'hF);
        wr(A_SEED, 32'hAABBCCDD, 4'h2);
        rd(A_DATA, v); check("R3 partial seed", v, 32'h1122CC44);

        // R2 control write without lane 0 strobe ignored
        wr(A_MODE, 32'h3F, 4'hE);
        rd(A_MODE, v); check("R2 mode needs lane0", v, 32'h02);

        // R9 pause, read raw, reseed, resume
        wr(A_MODE, 32'h36, 4'h1);
        wr(A_SEED, 32'hFFFFFFFF, 4'hF);
        e = 32'hFFFFFFFF;
        for (int i = 0; i < 4; i++) begin
            wr(A_DATA, {24'h0, str[i]}, 4'h1);
            e = ref_byte(e, flip8(str[i]), 2);
        end
        wr(A_MODE, 32'h06, 4'h1);
        rd(A_DATA, raw); check("R9 raw sum after mode change", raw, e);
        wr(A_SEED, 32'h0, 4'hF);
        wr(A_SEED, raw, 4'hF);
        wr(A_MODE, 32'h36, 4'h1);
        for (int i = 4; i < 9; i++) wr(A_DATA, {24'h0, str[i]}, 4'h1);
        rd(A_DATA, v); check("R9 resumed check value", v, 32'hCBF43926);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule